// File: doc/BRIEF.md
# Code-Gated Protected Byte Store

This block guards a 1024-entry array of bytes that models non-volatile storage. Every byte can always be read. Changing a byte needs two things: the user must first prove knowledge of a secret key, and the byte must not have been sealed. Each byte has a seal flag. A seal can be set but never cleared, so a sealed byte stays read-only for good. The secret key is kept in a small separate code space and reads never reveal it. A counter tracks consecutive wrong key attempts. At the limit it locks the block permanently, and from then on no key attempt and no modification is ever accepted.

Commands arrive on a single synchronous port, one at a time. Reads and key checks finish on the next cycle. An accepted write, erase or seal holds `busy` for a programmable number of cycles, which stands in for the cell programming time. A one-cycle `done` pulse then carries the status.

Top module: `secure_byte_store`

## Requirements
- R1: A read (op 0, `cmd_code_sel`=0) of any address is accepted in any state, including lockout. `done` pulses in the cycle after acceptance, with status 0 (OK) and `rdata` equal to the stored byte.
- R2: A read with `cmd_code_sel`=1 returns 0x00 in `rdata` with status OK for every code-space address, whatever the key holds.
- R3: Write (op 1), erase (op 2) and seal (op 3) are refused unless the unlocked flag is set and the block is not locked out. A refused command completes in the cycle after acceptance with status 1 (DENIED), and the array and the key are left unchanged.
- R4: An accepted write stores `cmd_wdata`, and an accepted erase stores 0xFF. `busy` is high for exactly PROG_CYCLES cycles, starting the cycle after acceptance, and `done` then pulses with status OK.
- R5: An accepted seal sets the seal flag of the addressed byte, with the same timing as R4. Writes and erases to a sealed byte are then DENIED and leave it unchanged. A seal flag is never cleared.
- R6: While `busy` is high, `cmd_valid` is ignored. `busy` and `done` are never high in the same cycle.
- R7: A key check (op 4) compares `cmd_key` with the stored key. On a match it returns status OK, clears `fail_count` and sets `unlocked`. On a mismatch it returns status 2 (MISMATCH) and increments `fail_count`.
- R8: When `fail_count` reaches MAX_FAILS (8), `locked_out` rises and stays high for good, including across reset. Key checks then return status 3 (LOCKED) with `fail_count` unchanged, and every write, erase and seal is DENIED.
- R9: Reset clears `unlocked` only. The fail count, the lockout, the seal flags, the array and the key are all kept.
- R10: Key byte i is bits [8i+7:8i] of the key and is addressed by code-space address i. Once unlocked, a write or erase with `cmd_code_sel`=1 changes that key byte. A seal aimed at the code space, or a code-space address of CODE_BYTES or more, is DENIED.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command request, taken when not busy |
| cmd_op | input | 3 | 0 read, 1 write, 2 erase, 3 seal, 4 key check |
| cmd_code_sel | input | 1 | Target the key code space instead of the array |
| cmd_addr | input | ADDR_W | Byte address (code byte index in code space) |
| cmd_wdata | input | 8 | Data for write |
| cmd_key | input | 8*CODE_BYTES | Key presented by a key check |
| busy | output | 1 | Programming in progress |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | 0 OK, 1 DENIED, 2 MISMATCH, 3 LOCKED |
| rdata | output | 8 | Read result, valid with `done` |
| unlocked | output | 1 | Key has been proven since reset |
| fail_count | output | clog2(MAX_FAILS+1) | Consecutive wrong key attempts |
| locked_out | output | 1 | Permanent lockout reached |

## Verification
The bench builds the block with the full 10-bit address space and a 3-byte key. It shortens PROG_CYCLES to 4, which makes it affordable to write, seal, rewrite, erase and read back every one of the 1024 bytes. Every fifth byte is sealed, so sealed and open bytes alternate throughout the sweeps, and each result is predicted from the address. The default MAX_FAILS of 8 is kept, so the bench steps through every counter value up to lockout. It also resets the block around the lockout to show that the lockout persists.

// File: rtl/sbs_pkg.sv
package sbs_pkg;

    localparam int BYTE_W = 8;
    localparam logic [BYTE_W-1:0] ERASED_BYTE = 8'hFF;
    localparam logic [BYTE_W-1:0] MASK_BYTE   = 8'h00;

    typedef enum logic [2:0] {
        OP_READ    = 3'd0,
        OP_WRITE   = 3'd1,
        OP_ERASE   = 3'd2,
        OP_PROTECT = 3'd3,
        OP_VERIFY  = 3'd4
    } op_e;

    typedef enum logic [1:0] {
        ST_OK       = 2'd0,
        ST_DENIED   = 2'd1,
        ST_MISMATCH = 2'd2,
        ST_LOCKED   = 2'd3
    } status_e;

    typedef enum logic {
        S_IDLE = 1'b0,
        S_PROG = 1'b1
    } state_e;

    function automatic logic is_prog_op(op_e op);
        return (op == OP_WRITE) || (op == OP_ERASE) || (op == OP_PROTECT);
    endfunction

endpackage

// File: rtl/sbs_fail_counter.sv
module sbs_fail_counter #(
    parameter int MAX_FAILS = 8,
    localparam int CNT_W = $clog2(MAX_FAILS + 1)
) (
    input  logic             clk,
    input  logic             fail_inc,
    input  logic             fail_clr,
    output logic [CNT_W-1:0] count,
    output logic             locked
);
    // Non-volatile: initial value is the delivered state, reset has no effect.
    logic [CNT_W-1:0] count_q = '0;

    always_ff @(posedge clk) begin
        if (!locked) begin
            if (fail_clr) begin
                count_q <= '0;
            end else if (fail_inc) begin
                count_q <= count_q + 1'b1;
            end
        end
    end

    assign count  = count_q;
    assign locked = (count_q >= CNT_W'(MAX_FAILS));
endmodule

// File: rtl/sbs_store.sv
module sbs_store
    import sbs_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int CODE_BYTES = 3,
    parameter logic [8*CODE_BYTES-1:0] DEFAULT_CODE = 24'h5A3C96,
    localparam int DEPTH = 1 << ADDR_W,
    localparam int IDX_W = (CODE_BYTES > 1) ? $clog2(CODE_BYTES) : 1
) (
    input  logic                    clk,
    input  logic                    we,
    input  logic                    we_code_sel,
    input  logic                    prot_set,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [BYTE_W-1:0]       wr_data,
    input  logic [ADDR_W-1:0]       rd_addr,
    output logic [BYTE_W-1:0]       rd_data,
    output logic                    rd_prot,
    output logic [8*CODE_BYTES-1:0] code_word,
    output logic [DEPTH-1:0]        prot_bits
);
    logic [BYTE_W-1:0]       mem_q [DEPTH] = '{default: ERASED_BYTE};
    logic [DEPTH-1:0]        prot_q = '0;
    logic [8*CODE_BYTES-1:0] code_q = DEFAULT_CODE;
    logic [IDX_W-1:0]        code_idx;

    assign code_idx = wr_addr[IDX_W-1:0];

    always_ff @(posedge clk) begin
        if (we && !we_code_sel) begin
            mem_q[wr_addr] <= wr_data;
        end
        if (prot_set) begin
            prot_q[wr_addr] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (we && we_code_sel) begin
            code_q[8*code_idx +: 8] <= wr_data;
        end
    end

    assign rd_data   = mem_q[rd_addr];
    assign rd_prot   = prot_q[rd_addr];
    assign code_word = code_q;
    assign prot_bits = prot_q;
endmodule

// File: rtl/sbs_ctrl.sv
module sbs_ctrl
    import sbs_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int CODE_BYTES = 3,
    parameter int PROG_CYCLES = 1250000,
    localparam int CNT_W = $clog2(PROG_CYCLES + 1),
    localparam int KEY_W = 8 * CODE_BYTES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic              cmd_code_sel,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [BYTE_W-1:0] cmd_wdata,
    input  logic [KEY_W-1:0]  cmd_key,
    input  logic [KEY_W-1:0]  code_word,
    input  logic              tgt_prot,
    input  logic [BYTE_W-1:0] arr_rdata,
    input  logic              locked,
    output logic              busy,
    output logic              done,
    output status_e           status,
    output logic [BYTE_W-1:0] rdata,
    output logic              unlocked,
    output logic              fail_inc,
    output logic              fail_clr,
    output logic              commit_we,
    output logic              commit_code_sel,
    output logic              commit_prot,
    output logic [ADDR_W-1:0] commit_addr,
    output logic [BYTE_W-1:0] commit_data
);
    state_e            state_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              done_q;
    logic              unlocked_q;
    status_e           status_q;
    logic [BYTE_W-1:0] rdata_q;
    op_e               pend_op;
    logic              pend_sel;
    logic [ADDR_W-1:0] pend_addr;
    logic [BYTE_W-1:0] pend_data;

    op_e  op;
    logic accept;
    logic key_match;
    logic target_ok;
    logic allowed;
    logic finishing;

    assign op        = op_e'(cmd_op);
    assign accept    = cmd_valid && (state_q == S_IDLE);
    assign key_match = (cmd_key == code_word);
    assign target_ok = cmd_code_sel
                     ? ((op != OP_PROTECT) && (cmd_addr < ADDR_W'(CODE_BYTES)))
                     : !tgt_prot;
    assign allowed   = unlocked_q && !locked && target_ok;
    assign finishing = (state_q == S_PROG) && (cnt_q == '0);

    assign fail_inc = accept && (op == OP_VERIFY) && !locked && !key_match;
    assign fail_clr = accept && (op == OP_VERIFY) && !locked && key_match;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= S_IDLE;
            cnt_q      <= '0;
            done_q     <= 1'b0;
            unlocked_q <= 1'b0;
            status_q   <= ST_OK;
            rdata_q    <= '0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                S_IDLE: begin
                    if (cmd_valid) begin
                        if (op == OP_READ) begin
                            rdata_q  <= cmd_code_sel ? MASK_BYTE : arr_rdata;
                            status_q <= ST_OK;
                            done_q   <= 1'b1;
                        end else if (op == OP_VERIFY) begin
                            done_q <= 1'b1;
                            if (locked) begin
                                status_q <= ST_LOCKED;
                            end else if (key_match) begin
                                status_q   <= ST_OK;
                                unlocked_q <= 1'b1;
                            end else begin
                                status_q <= ST_MISMATCH;
                            end
                        end else if (is_prog_op(op) && allowed) begin
                            state_q <= S_PROG;
                            cnt_q   <= CNT_W'(PROG_CYCLES - 1);
                        end else begin
                            status_q <= ST_DENIED;
                            done_q   <= 1'b1;
                        end
                    end
                end
                S_PROG: begin
                    if (cnt_q == '0) begin
                        state_q  <= S_IDLE;
                        status_q <= ST_OK;
                        done_q   <= 1'b1;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (accept) begin
            pend_op   <= op;
            pend_sel  <= cmd_code_sel;
            pend_addr <= cmd_addr;
            pend_data <= cmd_wdata;
        end
    end

    assign commit_we       = finishing && (pend_op != OP_PROTECT);
    assign commit_prot     = finishing && (pend_op == OP_PROTECT);
    assign commit_code_sel = pend_sel;
    assign commit_addr     = pend_addr;
    assign commit_data     = (pend_op == OP_ERASE) ? ERASED_BYTE : pend_data;

    assign busy     = (state_q == S_PROG);
    assign done     = done_q;
    assign status   = status_q;
    assign rdata    = rdata_q;
    assign unlocked = unlocked_q;
endmodule

// File: rtl/secure_byte_store.sv
module secure_byte_store
    import sbs_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int CODE_BYTES = 3,
    parameter logic [8*CODE_BYTES-1:0] DEFAULT_CODE = 24'h5A3C96,
    parameter int MAX_FAILS = 8,
    parameter int PROG_CYCLES = 1250000
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              cmd_valid,
    input  logic [2:0]                        cmd_op,
    input  logic                              cmd_code_sel,
    input  logic [ADDR_W-1:0]                 cmd_addr,
    input  logic [7:0]                        cmd_wdata,
    input  logic [8*CODE_BYTES-1:0]           cmd_key,
    output logic                              busy,
    output logic                              done,
    output logic [1:0]                        status,
    output logic [7:0]                        rdata,
    output logic                              unlocked,
    output logic [$clog2(MAX_FAILS+1)-1:0]    fail_count,
    output logic                              locked_out
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int KEY_W = 8 * CODE_BYTES;

    logic              fail_inc, fail_clr;
    logic              commit_we, commit_code_sel, commit_prot;
    logic [ADDR_W-1:0] commit_addr;
    logic [BYTE_W-1:0] commit_data;
    logic [BYTE_W-1:0] arr_rdata;
    logic              tgt_prot;
    logic [KEY_W-1:0]  code_word;
    logic [DEPTH-1:0]  prot_bits;
    status_e           status_e_w;

    sbs_fail_counter #(.MAX_FAILS(MAX_FAILS)) u_fails (
        .clk      (clk),
        .fail_inc (fail_inc),
        .fail_clr (fail_clr),
        .count    (fail_count),
        .locked   (locked_out)
    );

    sbs_store #(
        .ADDR_W(ADDR_W), .CODE_BYTES(CODE_BYTES), .DEFAULT_CODE(DEFAULT_CODE)
    ) u_store (
        .clk         (clk),
        .we          (commit_we),
        .we_code_sel (commit_code_sel),
        .prot_set    (commit_prot),
        .wr_addr     (commit_addr),
        .wr_data     (commit_data),
        .rd_addr     (cmd_addr),
        .rd_data     (arr_rdata),
        .rd_prot     (tgt_prot),
        .code_word   (code_word),
        .prot_bits   (prot_bits)
    );

    sbs_ctrl #(
        .ADDR_W(ADDR_W), .CODE_BYTES(CODE_BYTES), .PROG_CYCLES(PROG_CYCLES)
    ) u_ctrl (
        .clk             (clk),
        .rst             (rst),
        .cmd_valid       (cmd_valid),
        .cmd_op          (cmd_op),
        .cmd_code_sel    (cmd_code_sel),
        .cmd_addr        (cmd_addr),
        .cmd_wdata       (cmd_wdata),
        .cmd_key         (cmd_key),
        .code_word       (code_word),
        .tgt_prot        (tgt_prot),
        .arr_rdata       (arr_rdata),
        .locked          (locked_out),
        .busy            (busy),
        .done            (done),
        .status          (status_e_w),
        .rdata           (rdata),
        .unlocked        (unlocked),
        .fail_inc        (fail_inc),
        .fail_clr        (fail_clr),
        .commit_we       (commit_we),
        .commit_code_sel (commit_code_sel),
        .commit_prot     (commit_prot),
        .commit_addr     (commit_addr),
        .commit_data     (commit_data)
    );

    assign status = status_e_w;
endmodule

// File: rtl/sbs_checker.sv
module sbs_checker #(
    parameter int DEPTH = 1024,
    parameter int MAX_FAILS = 8,
    localparam int CNT_W = $clog2(MAX_FAILS + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             busy,
    input logic             done,
    input logic             unlocked,
    input logic             locked_out,
    input logic [CNT_W-1:0] fail_count,
    input logic             commit_we,
    input logic             commit_prot,
    input logic [DEPTH-1:0] prot
);
    // R6
    busy_done_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(busy && done));

    // R5
    seal_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        ((~prot) & $past(prot)) == '0);

    // R8
    lockout_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        $past(locked_out) |-> locked_out);

    // R8
    fail_bound_chk: assert property (@(posedge clk) disable iff (rst)
        fail_count <= CNT_W'(MAX_FAILS));

    // R3
    commit_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (commit_we || commit_prot) |-> (unlocked && !locked_out));
endmodule

bind secure_byte_store sbs_checker #(.DEPTH(DEPTH), .MAX_FAILS(MAX_FAILS)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .busy        (busy),
    .done        (done),
    .unlocked    (unlocked),
    .locked_out  (locked_out),
    .fail_count  (fail_count),
    .commit_we   (commit_we),
    .commit_prot (commit_prot),
    .prot        (prot_bits)
);

// File: tb/tb_secure_byte_store.sv
`timescale 1ns/1ps
module tb_secure_byte_store;
    localparam int P = 4;
    localparam int N = 1024;
    localparam logic [23:0] KEY0 = 24'h5A3C96;
    localparam logic [2:0] RD = 3'd0, WR = 3'd1, ER = 3'd2, PR = 3'd3, VF = 3'd4;
    localparam logic [1:0] OK = 2'd0, DEN = 2'd1, MIS = 2'd2, LCK = 2'd3;

    logic clk = 0, rst = 1;
    logic cmd_valid = 0, cmd_code_sel = 0;
    logic [2:0] cmd_op = 0;
    logic [9:0] cmd_addr = 0;
    logic [7:0] cmd_wdata = 0;
    logic [23:0] cmd_key = 0;
    logic busy, done, unlocked, locked_out;
    logic [1:0] status;
    logic [7:0] rdata;
    logic [3:0] fail_count;

    int n_chk = 0, n_fail = 0;
    int lat;
    logic [1:0] r_st;
    logic [7:0] r_dat;
    logic [23:0] key;

    always #2 clk = ~clk;

    secure_byte_store #(.PROG_CYCLES(P)) dut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_code_sel(cmd_code_sel), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
        .cmd_key(cmd_key), .busy(busy), .done(done), .status(status),
        .rdata(rdata), .unlocked(unlocked), .fail_count(fail_count),
        .locked_out(locked_out)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    task automatic cmd(input logic [2:0] op, input bit sel, input int a,
                       input logic [7:0] d, input logic [23:0] k);
        @(negedge clk);
        cmd_op = op; cmd_code_sel = sel; cmd_addr = 10'(a); cmd_wdata = d; cmd_key = k;
        cmd_valid = 1;
        @(negedge clk);
        cmd_valid = 0;
        lat = 0;
        while (!done && lat < 100) begin
            @(negedge clk);
            lat++;
        end
        r_st = status; r_dat = rdata;
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1;
        repeat (2) @(negedge clk);
        rst = 0;
    endtask

    function automatic logic [7:0] f(int i);
        return 8'((i * 37 + 5) & 255);
    endfunction

    function automatic bit sealed(int i);
        return (i % 5) == 0;
    endfunction

    task automatic prog_expect(input string req, input logic [1:0] st);
        chk(r_st == st, req, r_st, st);
        chk(lat == ((st == OK) ? P : 0), req, lat, (st == OK) ? P : 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        // R9 R6 reset state
        chk(!busy && !done && !unlocked, "R9 reset outputs", {busy, done, unlocked}, 0);
        chk(fail_count == 0 && !locked_out, "R8 initial counter", fail_count, 0);

        // R1 initial array contents, latency
        for (int i = 0; i < N; i++) begin
            cmd(RD, 0, i, 0, 0);
            chk(r_dat == 8'hFF && r_st == OK && lat == 0, "R1 initial read", r_dat, 8'hFF);
        end
        // R2 code space masked
        for (int i = 0; i < 4; i++) begin
            cmd(RD, 1, i, 0, 0);
            chk(r_dat == 8'h00 && r_st == OK, "R2 code read masked", r_dat, 0);
        end

        // R3 modification refused before unlock
        cmd(WR, 0, 5, 8'h12, 0); prog_expect("R3 write locked", DEN);
        cmd(ER, 0, 5, 0, 0);     prog_expect("R3 erase locked", DEN);
        cmd(PR, 0, 6, 0, 0);     prog_expect("R3 seal locked", DEN);
        cmd(WR, 1, 0, 8'h12, 0); prog_expect("R3 key write locked", DEN);
        cmd(RD, 0, 5, 0, 0);
        chk(r_dat == 8'hFF, "R3 array untouched", r_dat, 8'hFF);
        cmd(WR, 0, 6, 8'h34, 0); prog_expect("R3 seal had no effect", DEN);

        // R7 key check
        cmd(VF, 0, 0, 0, KEY0 ^ 24'h1);
        chk(r_st == MIS && fail_count == 1, "R7 mismatch", {r_st, fail_count}, {MIS, 4'd1});
        cmd(VF, 0, 0, 0, KEY0);
        chk(r_st == OK && fail_count == 0 && unlocked, "R7 match", {r_st, fail_count, unlocked}, 1);

        // R4 write sweep with busy window
        for (int i = 0; i < N; i++) begin
            cmd(WR, 0, i, f(i), 0); prog_expect("R4 write", OK);
        end
        for (int i = 0; i < N; i++) begin
            cmd(RD, 0, i, 0, 0);
            chk(r_dat == f(i), "R4 write readback", r_dat, f(i));
        end

        // R5 seal every fifth byte
        for (int i = 0; i < N; i += 5) begin
            cmd(PR, 0, i, 0, 0); prog_expect("R5 seal", OK);
        end
        for (int i = 0; i < N; i++) begin
            cmd(WR, 0, i, ~f(i), 0);
            prog_expect("R5 write vs seal", sealed(i) ? DEN : OK);
        end
        for (int i = 0; i < N; i++) begin
            cmd(RD, 0, i, 0, 0);
            chk(r_dat == (sealed(i) ? f(i) : ~f(i)), "R5 rewrite readback", r_dat,
                sealed(i) ? f(i) : ~f(i));
        end
        for (int i = 0; i < N; i++) begin
            cmd(ER, 0, i, 0, 0);
            prog_expect("R4 R5 erase", sealed(i) ? DEN : OK);
        end
        for (int i = 0; i < N; i++) begin
            cmd(RD, 0, i, 0, 0);
            chk(r_dat == (sealed(i) ? f(i) : 8'hFF), "R4 R5 erase readback", r_dat,
                sealed(i) ? f(i) : 8'hFF);
        end

        // R6 command during busy is ignored
        @(negedge clk);
        cmd_op = WR; cmd_code_sel = 0; cmd_addr = 1; cmd_wdata = 8'h42; cmd_valid = 1;
        @(negedge clk);
        chk(busy == 1, "R6 busy after accept", busy, 1);
        cmd_addr = 2; cmd_wdata = 8'h99;
        repeat (2) @(negedge clk);
        cmd_valid = 0;
        lat = 0;
        while (!done && lat < 100) begin @(negedge clk); lat++; end
        chk(!busy, "R6 busy low with done", busy, 0);
        @(negedge clk);
        chk(!done && !busy, "R6 no second command", {done, busy}, 0);
        cmd(RD, 0, 2, 0, 0);
        chk(r_dat == 8'hFF, "R6 ignored write", r_dat, 8'hFF);
        cmd(RD, 0, 1, 0, 0);
        chk(r_dat == 8'h42, "R6 first write", r_dat, 8'h42);

        // R10 key space
        cmd(PR, 1, 0, 0, 0);     prog_expect("R10 seal key denied", DEN);
        cmd(WR, 1, 3, 8'h77, 0); prog_expect("R10 key index range", DEN);
        cmd(WR, 1, 0, 8'h11, 0); prog_expect("R10 key write", OK);
        cmd(RD, 1, 0, 0, 0);
        chk(r_dat == 8'h00, "R2 key byte still masked", r_dat, 0);
        cmd(VF, 0, 0, 0, KEY0);
        chk(r_st == MIS && fail_count == 1, "R10 old key rejected", r_st, MIS);
        key = {KEY0[23:8], 8'h11};
        cmd(VF, 0, 0, 0, key);
        chk(r_st == OK && fail_count == 0, "R10 new key", {r_st, fail_count}, 0);
        cmd(ER, 1, 1, 0, 0); prog_expect("R10 key erase", OK);
        key = {KEY0[23:16], 8'hFF, 8'h11};
        cmd(VF, 0, 0, 0, key);
        chk(r_st == OK, "R10 erased key byte", r_st, OK);

        // R9 reset keeps non-volatile state
        cmd(VF, 0, 0, 0, ~key);
        cmd(VF, 0, 0, 0, ~key);
        do_reset();
        chk(!unlocked, "R9 unlocked cleared", unlocked, 0);
        chk(fail_count == 2, "R9 count kept", fail_count, 2);
        cmd(RD, 0, 1, 0, 0);
        chk(r_dat == 8'h42, "R9 array kept", r_dat, 8'h42);
        cmd(WR, 0, 1, 8'h00, 0); prog_expect("R9 R3 denied after reset", DEN);
        cmd(VF, 0, 0, 0, key);
        chk(r_st == OK && fail_count == 0, "R7 count cleared", fail_count, 0);
        cmd(WR, 0, 0, 8'h00, 0); prog_expect("R9 R5 seal kept", DEN);

        // R8 lockout
        for (int k = 1; k <= 8; k++) begin
            cmd(VF, 0, 0, 0, ~key);
            chk(r_st == MIS && fail_count == 4'(k), "R8 count step", fail_count, k);
            chk(locked_out == (k == 8), "R8 lock edge", locked_out, k == 8);
        end
        cmd(VF, 0, 0, 0, key);
        chk(r_st == LCK && fail_count == 8, "R8 check locked", r_st, LCK);
        cmd(WR, 0, 1, 8'h55, 0); prog_expect("R8 write denied", DEN);
        cmd(ER, 0, 1, 0, 0);     prog_expect("R8 erase denied", DEN);
        cmd(RD, 0, 1, 0, 0);
        chk(r_dat == 8'h42 && r_st == OK, "R1 R8 read in lockout", r_dat, 8'h42);
        do_reset();
        chk(locked_out && fail_count == 8, "R8 R9 lock survives reset", locked_out, 1);
        cmd(VF, 0, 0, 0, key);
        chk(r_st == LCK && !unlocked, "R8 locked after reset", r_st, LCK);

        finish_run();
    end
endmodule